// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block sits between decode and the issue queues of an out-of-order core. Each cycle it can take a group of two instructions. Every instruction in the group names up to two source registers and one destination register out of 32 architected registers. The block looks up the sources in a map table, which holds the physical register that carries each architected register's newest value. Each instruction that writes a register receives a fresh tag from a free list of 64 physical registers. The block also reports the tag the destination was mapped to before the group, so that the tag can be released later.

The second instruction of a group may read or overwrite a register that the first instruction writes. The unit resolves that dependence inside the same cycle, so the group behaves as if its two instructions had been renamed one after the other. A displaced tag stays in use until the retirement logic commits the later writer of the same architected register. The retirement logic then hands the tag back through the commit ports, up to two per cycle and in program order. If the free list cannot supply every writer in the group, the whole group waits.

Lookups are combinational. Map-table and free-list updates take effect at the clock edge on which the group is accepted.

Top module: `rename_unit`

## Requirements
- R1: Out of reset, architected register i maps to physical tag i for all 32 registers, and the free list holds tags 32..63 in ascending order.
- R2: An accepted group hands out tags in free-list order, lane 0 before lane 1, and the two lanes never receive the same tag in one group.
- R3: A source that is not written earlier in its own group reads the tag recorded by the most recent accepted writer of that register in an earlier group.
- R4: A lane-1 source (A or B) that equals lane 0's destination, when lane 0 writes, reads lane 0's new tag instead of the map table entry.
- R5: For each writing lane, outOldTag is the tag that its destination held before the group, and it differs from the new tag that lane receives.
- R6: When both lanes write the same architected register, lane 1's old tag equals lane 0's new tag, and afterwards the map table holds lane 1's new tag.
- R7: When inValid is high and the free list holds fewer tags than the group has writers (inWrEn bit k set means lane k writes), stall is high, renAck is low, and neither the map table nor the free list changes.
- R8: A lane with inWrEn low consumes no free tag, changes no mapping, and does not by itself cause a stall.
- R9: Each tag presented with cmtValid is appended to the tail of the free list, lane 0 before lane 1, in the same cycle. Tags returned this way are handed out again after the tags already queued.
- R10: With inValid low, renAck and stall are low and the rename state is unchanged, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A rename group is presented |
| inWrEn | input | 2 | Per lane: the instruction writes a destination |
| inSrcA | input | 2x5 | Per lane: first source architected register |
| inSrcB | input | 2x5 | Per lane: second source architected register |
| inDst | input | 2x5 | Per lane: destination architected register |
| cmtValid | input | 2 | Per lane: a tag is returned by commit |
| cmtTag | input | 2x6 | Per lane: physical tag returned to the free list |
| stall | output | 1 | The group cannot be renamed this cycle |
| renAck | output | 1 | The group is renamed at this clock edge |
| outSrcA | output | 2x6 | Per lane: physical tag for the first source |
| outSrcB | output | 2x6 | Per lane: physical tag for the second source |
| outNewTag | output | 2x6 | Per lane: freshly allocated destination tag |
| outOldTag | output | 2x6 | Per lane: displaced destination tag |

## Verification
A corrupted map-table entry shows up on outSrcA or outSrcB the first time any later group reads that register. The bench's model tracks every mapping, so the error is reported on that cycle. A free-list pointer or count that drifts is seen on outNewTag at the next allocation, or as a stall that comes one group too early or too late. A tag that is lost or duplicated only appears once the list wraps. The long sweep therefore cycles every tag through allocation and commit many times, while the eight-register pool keeps same-group collisions frequent.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int LANES  = 2;
  localparam int ARCH_N = 32;
  localparam int PHYS_N = 64;
  localparam int ARCH_W = $clog2(ARCH_N);
  localparam int TAG_W  = $clog2(PHYS_N);

  // Strobes from control to the storage blocks
  typedef struct packed {
    logic             fire;
    logic [LANES-1:0] alloc;
  } rnStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int CNT_W = 7
) (
  input  logic             inValid,
  input  logic [NLANE-1:0] wrEn,
  input  logic [CNT_W-1:0] freeCnt,
  output logic             stall,
  output logic             ack,
  output rnStrobe_t        strobe
);
  logic [CNT_W-1:0] need;

  always_comb begin
    need = '0;
    for (int k = 0; k < NLANE; k++) begin
      need = need + CNT_W'(wrEn[k]);
    end
  end

  always_comb begin
    stall        = inValid && (freeCnt < need);
    ack          = inValid && !stall;
    strobe.fire  = ack;
    strobe.alloc = ack ? wrEn : '0;
  end
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int PHYS_N = 64,
  parameter int ARCH_N = 32,
  parameter int NLANE  = 2,
  parameter int TAG_W  = $clog2(PHYS_N),
  parameter int CNT_W  = $clog2(PHYS_N + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NLANE-1:0]            alloc,
  input  logic [NLANE-1:0]            retValid,
  input  logic [NLANE-1:0][TAG_W-1:0] retTag,
  output logic [NLANE-1:0][TAG_W-1:0] grantTag,
  output logic [CNT_W-1:0]            freeCnt
);
  localparam int PTR_W    = $clog2(PHYS_N);
  localparam int INIT_CNT = PHYS_N - ARCH_N;

  logic [TAG_W-1:0] slots [PHYS_N];
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] popIdx  [NLANE];
  logic [PTR_W-1:0] pushIdx [NLANE];
  logic [PTR_W-1:0] popOff, pushOff;
  logic [CNT_W-1:0] popN, pushN;

  always_comb begin
    popOff  = '0;
    pushOff = '0;
    popN    = '0;
    pushN   = '0;
    for (int k = 0; k < NLANE; k++) begin
      popIdx[k]  = headPtr + popOff;
      pushIdx[k] = tailPtr + pushOff;
      popOff     = popOff + PTR_W'(alloc[k]);
      pushOff    = pushOff + PTR_W'(retValid[k]);
      popN       = popN + CNT_W'(alloc[k]);
      pushN      = pushN + CNT_W'(retValid[k]);
    end
  end

  generate
    for (genvar g = 0; g < NLANE; g++) begin : gGrant
      assign grantTag[g] = slots[popIdx[g]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_N; i++) begin
        slots[i] <= (i < INIT_CNT) ? TAG_W'(ARCH_N + i) : '0;
      end
      headPtr <= '0;
      tailPtr <= PTR_W'(INIT_CNT);
      cnt     <= CNT_W'(INIT_CNT);
    end else begin
      for (int k = 0; k < NLANE; k++) begin
        if (retValid[k]) slots[pushIdx[k]] <= retTag[k];
      end
      headPtr <= headPtr + PTR_W'(popN);
      tailPtr <= tailPtr + PTR_W'(pushN);
      cnt     <= cnt + pushN - popN;
    end
  end

  assign freeCnt = cnt;
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int NARCH = ARCH_N,
  parameter int NLANE = LANES,
  parameter int AW    = $clog2(NARCH),
  parameter int TW    = TAG_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rnStrobe_t                strobe,
  input  logic [NLANE-1:0]         wrEn,
  input  logic [NLANE-1:0][AW-1:0] srcA,
  input  logic [NLANE-1:0][AW-1:0] srcB,
  input  logic [NLANE-1:0][AW-1:0] dst,
  input  logic [NLANE-1:0][TW-1:0] newTag,
  output logic [NLANE-1:0][TW-1:0] physA,
  output logic [NLANE-1:0][TW-1:0] physB,
  output logic [NLANE-1:0][TW-1:0] oldTag
);
  logic [TW-1:0] mapTbl [NARCH];

  // Table lookup, then override by any earlier writing lane (latest wins)
  always_comb begin
    for (int k = 0; k < NLANE; k++) begin
      physA[k]  = mapTbl[srcA[k]];
      physB[k]  = mapTbl[srcB[k]];
      oldTag[k] = mapTbl[dst[k]];
      for (int j = 0; j < k; j++) begin
        if (wrEn[j] && dst[j] == srcA[k]) physA[k]  = newTag[j];
        if (wrEn[j] && dst[j] == srcB[k]) physB[k]  = newTag[j];
        if (wrEn[j] && dst[j] == dst[k])  oldTag[k] = newTag[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NARCH; i++) mapTbl[i] <= TW'(i);
    end else if (strobe.fire) begin
      for (int k = 0; k < NLANE; k++) begin
        if (strobe.alloc[k]) mapTbl[dst[k]] <= newTag[k];
      end
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int NARCH = ARCH_N,
  parameter int NPHYS = PHYS_N,
  localparam int AW   = $clog2(NARCH),
  localparam int TW   = $clog2(NPHYS),
  localparam int CW   = $clog2(NPHYS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [NLANE-1:0]         inWrEn,
  input  logic [NLANE-1:0][AW-1:0] inSrcA,
  input  logic [NLANE-1:0][AW-1:0] inSrcB,
  input  logic [NLANE-1:0][AW-1:0] inDst,
  input  logic [NLANE-1:0]         cmtValid,
  input  logic [NLANE-1:0][TW-1:0] cmtTag,
  output logic                     stall,
  output logic                     renAck,
  output logic [NLANE-1:0][TW-1:0] outSrcA,
  output logic [NLANE-1:0][TW-1:0] outSrcB,
  output logic [NLANE-1:0][TW-1:0] outNewTag,
  output logic [NLANE-1:0][TW-1:0] outOldTag
);
  rnStrobe_t               strobe;
  logic [CW-1:0]           freeCnt;
  logic [NLANE-1:0][TW-1:0] grantTag;

  rename_ctrl #(.NLANE(NLANE), .CNT_W(CW)) ctrl_i (
    .inValid(inValid), .wrEn(inWrEn), .freeCnt(freeCnt),
    .stall(stall), .ack(renAck), .strobe(strobe)
  );

  rename_freelist #(.PHYS_N(NPHYS), .ARCH_N(NARCH), .NLANE(NLANE),
                    .TAG_W(TW), .CNT_W(CW)) free_i (
    .clk(clk), .rstN(rstN), .alloc(strobe.alloc),
    .retValid(cmtValid), .retTag(cmtTag),
    .grantTag(grantTag), .freeCnt(freeCnt)
  );

  rename_datapath #(.NARCH(NARCH), .NLANE(NLANE), .AW(AW), .TW(TW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(inWrEn),
    .srcA(inSrcA), .srcB(inSrcB), .dst(inDst), .newTag(grantTag),
    .physA(outSrcA), .physB(outSrcB), .oldTag(outOldTag)
  );

  assign outNewTag = grantTag;
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int AW = 5,
  parameter int TW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        inWrEn,
  input logic [1:0][AW-1:0] inSrcA,
  input logic [1:0][AW-1:0] inDst,
  input logic              stall,
  input logic              renAck,
  input logic [1:0][TW-1:0] outSrcA,
  input logic [1:0][TW-1:0] outNewTag,
  input logic [1:0][TW-1:0] outOldTag
);
  AST_STALL_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !renAck); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!renAck && !stall)); // R10

  AST_UNIQUE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (renAck && inWrEn == 2'b11) |-> (outNewTag[0] != outNewTag[1])); // R2

  AST_BYPASS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (renAck && inWrEn[0] && inDst[0] == inSrcA[1]) |-> (outSrcA[1] == outNewTag[0])); // R4

  AST_SAME_DST_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (renAck && inWrEn == 2'b11 && inDst[0] == inDst[1]) |-> (outOldTag[1] == outNewTag[0])); // R6

  AST_OLD_NOT_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (renAck && inWrEn[0]) |-> (outOldTag[0] != outNewTag[0])); // R5
endmodule

bind rename_unit rename_unit_chk #(.AW(AW), .TW(TW)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inWrEn(inWrEn),
  .inSrcA(inSrcA), .inDst(inDst), .stall(stall), .renAck(renAck),
  .outSrcA(outSrcA), .outNewTag(outNewTag), .outOldTag(outOldTag)
);

// File: tb/rename_unit_tb_top.sv
module rename_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inWrEn = '0;
  logic [1:0][4:0] inSrcA = '0, inSrcB = '0, inDst = '0;
  logic [1:0] cmtValid = '0;
  logic [1:0][5:0] cmtTag = '0;
  logic stall, renAck;
  logic [1:0][5:0] outSrcA, outSrcB, outNewTag, outOldTag;

  int checks = 0, errors = 0;
  int mapM [32];
  int flM [64];
  int flHead, flTail, flCnt;
  int pend [256];
  int pHead, pTail, pCnt;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rename_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWrEn(inWrEn),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .cmtValid(cmtValid), .cmtTag(cmtTag), .stall(stall), .renAck(renAck),
    .outSrcA(outSrcA), .outSrcB(outSrcB), .outNewTag(outNewTag), .outOldTag(outOldTag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int takePend();
    int t = pend[pHead];
    pHead = (pHead + 1) % 256;
    pCnt--;
    return t;
  endfunction

  // Drive one group at the falling edge, check before the rising edge, update model after it
  task automatic runGroup(input logic v, input logic [1:0] we,
                          input int sa0, input int sb0, input int d0,
                          input int sa1, input int sb1, input int d1,
                          input logic [1:0] cv, input int ct0, input int ct1,
                          input string tag);
    int need, n0, n1, eA0, eB0, eA1, eB1, o0, o1;
    logic expStall, expAck;
    inValid = v; inWrEn = we;
    inSrcA[0] = 5'(sa0); inSrcB[0] = 5'(sb0); inDst[0] = 5'(d0);
    inSrcA[1] = 5'(sa1); inSrcB[1] = 5'(sb1); inDst[1] = 5'(d1);
    cmtValid = cv; cmtTag[0] = 6'(ct0); cmtTag[1] = 6'(ct1);
    #1;
    need = v ? (int'(we[0]) + int'(we[1])) : 0;
    expStall = v && (flCnt < need);
    expAck = v && !expStall;
    n0 = flM[flHead];
    n1 = flM[(flHead + int'(we[0])) % 64];
    eA0 = mapM[sa0]; eB0 = mapM[sb0]; o0 = mapM[d0];
    eA1 = (we[0] && d0 == sa1) ? n0 : mapM[sa1];
    eB1 = (we[0] && d0 == sb1) ? n0 : mapM[sb1];
    o1  = (we[0] && d0 == d1) ? n0 : mapM[d1];
    chk(v ? "R7" : "R10", "stall", int'(stall), int'(expStall));
    chk(v ? "R7" : "R10", "renAck", int'(renAck), int'(expAck));
    if (expAck) begin
      chk(tag, "srcA lane0", int'(outSrcA[0]), eA0);
      chk(tag, "srcB lane0", int'(outSrcB[0]), eB0);
      chk((we[0] && d0 == sa1) ? "R4" : tag, "srcA lane1", int'(outSrcA[1]), eA1);
      chk((we[0] && d0 == sb1) ? "R4" : tag, "srcB lane1", int'(outSrcB[1]), eB1);
      if (we[0]) begin
        chk(tag, "newTag lane0", int'(outNewTag[0]), n0);
        chk("R5", "oldTag lane0", int'(outOldTag[0]), o0);
      end
      if (we[1]) begin
        chk(tag, "newTag lane1", int'(outNewTag[1]), n1);
        chk((we[0] && d0 == d1) ? "R6" : "R5", "oldTag lane1", int'(outOldTag[1]), o1);
      end
    end
    @(posedge clk);
    if (expAck) begin
      if (we[0]) begin
        mapM[d0] = n0; flHead = (flHead + 1) % 64; flCnt--;
        pend[pTail] = o0; pTail = (pTail + 1) % 256; pCnt++;
      end
      if (we[1]) begin
        mapM[d1] = n1; flHead = (flHead + 1) % 64; flCnt--;
        pend[pTail] = o1; pTail = (pTail + 1) % 256; pCnt++;
      end
    end
    if (cv[0]) begin flM[flTail] = ct0; flTail = (flTail + 1) % 64; flCnt++; end
    if (cv[1]) begin flM[flTail] = ct1; flTail = (flTail + 1) % 64; flCnt++; end
    @(negedge clk);
  endtask

  task automatic commitTwo(input string tag);
    int c0, c1;
    c0 = takePend();
    c1 = takePend();
    runGroup(1'b0, 2'b11, 1, 2, 3, 4, 5, 6, 2'b11, c0, c1, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mapM[i] = i;
    for (int i = 0; i < 64; i++) flM[i] = (i < 32) ? 32 + i : 0;
    flHead = 0; flTail = 32; flCnt = 32;
    pHead = 0; pTail = 0; pCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: identity map after reset, every register read once
    for (int g = 0; g < 8; g++)
      runGroup(1'b1, 2'b00, 4*g, 4*g+1, 0, 4*g+2, 4*g+3, 0, 2'b00, 0, 0, "R1");
    // R1: first allocations come from 32 upward
    runGroup(1'b1, 2'b11, 1, 2, 3, 3, 1, 4, 2'b00, 0, 0, "R1");
    // R3: later group sees previous writers
    runGroup(1'b1, 2'b00, 3, 4, 0, 4, 3, 0, 2'b00, 0, 0, "R3");
    // R6: both lanes write register 5
    runGroup(1'b1, 2'b11, 5, 5, 5, 5, 6, 5, 2'b00, 0, 0, "R6");
    runGroup(1'b1, 2'b00, 5, 6, 0, 5, 5, 0, 2'b00, 0, 0, "R6");
    // R8: lane 1 alone writes; it takes the next tag
    runGroup(1'b1, 2'b00, 1, 1, 9, 2, 2, 9, 2'b00, 0, 0, "R8");
    runGroup(1'b1, 2'b10, 9, 9, 9, 9, 9, 9, 2'b00, 0, 0, "R8");
    // R10: idle cycle with writers flagged, then state unchanged
    runGroup(1'b0, 2'b11, 9, 9, 9, 9, 9, 9, 2'b00, 0, 0, "R10");
    runGroup(1'b1, 2'b01, 9, 5, 12, 3, 12, 0, 2'b00, 0, 0, "R10");
    // R5: chain of writers to one register
    runGroup(1'b1, 2'b01, 12, 12, 12, 0, 0, 0, 2'b00, 0, 0, "R5");
    // R2: drain the list two at a time
    while (flCnt >= 2) runGroup(1'b1, 2'b11, 10, 11, 10, 10, 11, 11, 2'b00, 0, 0, "R2");
    // R7: boundary stalls
    if (flCnt == 1) begin
      runGroup(1'b1, 2'b11, 1, 2, 13, 3, 4, 14, 2'b00, 0, 0, "R7");
      runGroup(1'b1, 2'b01, 13, 2, 13, 13, 4, 0, 2'b00, 0, 0, "R7");
    end
    runGroup(1'b1, 2'b10, 1, 2, 0, 3, 4, 15, 2'b00, 0, 0, "R7");
    runGroup(1'b1, 2'b00, 15, 13, 0, 10, 11, 0, 2'b00, 0, 0, "R8");
    // R9: return tags, then reuse them in order
    commitTwo("R9");
    commitTwo("R9");
    runGroup(1'b1, 2'b11, 1, 2, 16, 16, 3, 17, 2'b00, 0, 0, "R9");
    runGroup(1'b1, 2'b11, 16, 17, 18, 18, 16, 19, 2'b00, 0, 0, "R9");
    runGroup(1'b1, 2'b11, 18, 19, 20, 1, 2, 21, 2'b00, 0, 0, "R7");

    // R2: long sweep over an eight-register pool with concurrent commits
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] cv;
      int c0, c1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cv = '0; c0 = 0; c1 = 0;
      if (lfsr[0] && pCnt > 0) begin cv[0] = 1'b1; c0 = takePend(); end
      if (lfsr[1] && pCnt > 0) begin cv[1] = 1'b1; c1 = takePend(); end
      runGroup(lfsr[2] | lfsr[3], lfsr[5:4], int'(lfsr[8:6]), int'(lfsr[11:9]),
               int'(lfsr[14:12]), int'(lfsr[10:8]), int'(lfsr[13:11]),
               int'({lfsr[15], lfsr[1:0]}), cv, c0, c1, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule